// File: doc/BRIEF.md
# Serial FIFO Status Word

This block assembles a single 32-bit status word for one serial peripheral that owns a receive FIFO and a transmit FIFO. It takes the live fill levels of both FIFOs, the two programmed threshold levels, the transmit-enable state and two single-cycle event pulses. From these it builds a word that carries threshold flags, empty flags, the receive entry count, the transmit free-space count, and two sticky event flags.

A processor reads the word through a simple strobe port. A read strobe captures the word into the output register, so `rd_data` is valid one clock after `rd_en` and holds its value until the next strobe. A write strobe clears sticky event flags: writing 1 to an event bit clears that flag. All other bits of a write are ignored. The FIFOs, the timeout generator and the bus protocol are outside the block.

Top module: `sfs_status_reg`

## Requirements
- R1: While `rst` is high and after it is released, before any read, `rd_data` equals 32'h0000_0300: both empty bits are 1 and every other bit is 0. Both sticky flags are clear.
- R2: Bit 0 of a captured word is 1 exactly when `rx_level >= rx_thresh` in the strobe cycle.
- R3: Bit 1 of a captured word is 1 exactly when `tx_level <= tx_thresh` in the strobe cycle.
- R4: A high `rx_timeout` pulse sets a sticky flag that reads at bit 4. The flag stays set until a write with bit 4 = 1 clears it. A read captures the flag value from before that cycle's update.
- R5: A high `bus_error` pulse sets a sticky flag that reads at bit 7. The flag stays set until a write with bit 7 = 1 clears it.
- R6: When an event pulse and a write-1 clear of the same flag fall in the same cycle, the flag ends that cycle set.
- R7: A write leaves a sticky flag set if the written value has 0 in that flag's bit, whatever the other bits of the write are.
- R8: Bit 8 is 1 exactly when `rx_level` is 0. Bit 9 is 1 exactly when `tx_level` is 0.
- R9: Bits 23:16 hold `rx_level`, zero-extended.
- R10: Bits 31:24 hold `DEPTH - tx_level` when `tx_enable` is 1, and 0 when `tx_enable` is 0.
- R11: Bits 3:2, 6:5 and 15:10 always read 0.
- R12: When `rd_en` is low, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | CNT_W | Entries held in the receive FIFO |
| tx_level | input | CNT_W | Entries held in the transmit FIFO |
| rx_thresh | input | CNT_W | Receive threshold level |
| tx_thresh | input | CNT_W | Transmit threshold level |
| tx_enable | input | 1 | Transmit FIFO configured and enabled |
| rx_timeout | input | 1 | Receive timeout event pulse |
| bus_error | input | 1 | Bus error event pulse |
| wr_en | input | 1 | Write strobe (write-1-to-clear) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Captured status word |

## Verification
The only internal state is the two sticky flags and the output register. A flag that is lost or never cleared shows up at bit 4 or bit 7 on the first read after the event or the clear. A corrupted output register shows up at once, as a word that changes without a strobe. The bench runs a behavioural model and compares every field of `rd_data` on every clock, so each such fault is reported in the cycle it first becomes visible. The event-against-clear collision and writes with mixed bit patterns get their own steps.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 8;
  localparam int NUM_EVT  = 2;
  localparam int B_RX_TH  = 0;
  localparam int B_TX_TH  = 1;
  localparam int B_RX_EMP = 8;
  localparam int B_TX_EMP = 9;
  localparam int F_RX_CNT = 16;
  localparam int F_TX_FREE = 24;
  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_0300;

  // event index 0: receive timeout, index 1: bus error
  function automatic int evt_bit(input int idx);
    return (idx == 0) ? 4 : 7;
  endfunction

  typedef struct packed {
    logic               rx_th;
    logic               tx_th;
    logic               rx_empty;
    logic               tx_empty;
    logic [FIELD_W-1:0] rx_cnt;
    logic [FIELD_W-1:0] tx_free;
  } level_view_t;

  function automatic logic [WORD_W-1:0] pack_word(input level_view_t v,
                                                  input logic [NUM_EVT-1:0] evt);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_RX_TH]  = v.rx_th;
    w[B_TX_TH]  = v.tx_th;
    w[B_RX_EMP] = v.rx_empty;
    w[B_TX_EMP] = v.tx_empty;
    w[F_RX_CNT +: FIELD_W]  = v.rx_cnt;
    w[F_TX_FREE +: FIELD_W] = v.tx_free;
    for (int i = 0; i < NUM_EVT; i++) w[evt_bit(i)] = evt[i];
    return w;
  endfunction
endpackage

// File: rtl/sfs_sticky.sv
module sfs_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // the set term is ORed last, so a set in the clear cycle survives
  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/sfs_level_view.sv
module sfs_level_view
  import sfs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_thresh,
  input  logic [CNT_W-1:0] tx_thresh,
  input  logic             tx_enable,
  output level_view_t      view
);
  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

  logic [CNT_W-1:0] free_slots;

  always_comb begin
    free_slots    = tx_enable ? (DEPTH_V - tx_level) : '0;
    view.rx_th    = (rx_level >= rx_thresh);
    view.tx_th    = (tx_level <= tx_thresh);
    view.rx_empty = (rx_level == '0);
    view.tx_empty = (tx_level == '0);
    view.rx_cnt   = FIELD_W'(rx_level);
    view.tx_free  = FIELD_W'(free_slots);
  end
endmodule

// File: rtl/sfs_status_reg.sv
module sfs_status_reg
  import sfs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_thresh,
  input  logic [CNT_W-1:0]  tx_thresh,
  input  logic              tx_enable,
  input  logic              rx_timeout,
  input  logic              bus_error,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data
);
  level_view_t        view;
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] evt_q;

  assign evt_set = {bus_error, rx_timeout};

  sfs_level_view #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_view (
    .rx_level (rx_level),
    .tx_level (tx_level),
    .rx_thresh(rx_thresh),
    .tx_thresh(tx_thresh),
    .tx_enable(tx_enable),
    .view     (view)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    sfs_sticky i_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (evt_set[g]),
      .clr_i (wr_en & wr_data[evt_bit(g)]),
      .flag_o(evt_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= RESET_WORD;
    else if (rd_en) rd_data <= pack_word(view, evt_q);
  end
endmodule

// File: rtl/sfs_status_chk.sv
module sfs_status_chk
  import sfs_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [CNT_W-1:0]  rx_level,
  input logic              tx_enable,
  input logic              rx_timeout,
  input logic              bus_error,
  input logic [NUM_EVT-1:0] evt_q,
  input logic [WORD_W-1:0] rd_data
);
  a_r12_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & 32'h0000_FC6C) == 32'h0);

  a_r6_timeout_set_wins: assert property (@(posedge clk) disable iff (rst)
    rx_timeout |=> evt_q[0]);

  a_r6_buserr_set_wins: assert property (@(posedge clk) disable iff (rst)
    bus_error |=> evt_q[1]);

  a_r4_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
    (evt_q[0] && !(wr_en && wr_data[4])) |=> evt_q[0]);

  a_r5_buserr_sticky: assert property (@(posedge clk) disable iff (rst)
    (evt_q[1] && !(wr_en && wr_data[7])) |=> evt_q[1]);

  a_r10_free_zero_when_off: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !tx_enable) |=> rd_data[31:24] == 8'h0);

  a_r9_rx_count: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data[23:16] == 8'($past(rx_level)));
endmodule

bind sfs_status_reg sfs_status_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rx_level  (rx_level),
  .tx_enable (tx_enable),
  .rx_timeout(rx_timeout),
  .bus_error (bus_error),
  .evt_q     (evt_q),
  .rd_data   (rd_data)
);

// File: tb/test_sfs_status_reg.sv
module test_sfs_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] rx_level = '0, tx_level = '0, rx_thresh = '0, tx_thresh = '0;
  logic             tx_enable = 1'b0, rx_timeout = 1'b0, bus_error = 1'b0;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  logic [31:0] m_rd = 32'h0000_0300;
  bit m_to = 0, m_be = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfs_status_reg #(.DEPTH(DEPTH)) i_sfs_status_reg (
    .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
    .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .tx_enable(tx_enable),
    .rx_timeout(rx_timeout), .bus_error(bus_error), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string scen);
    chk({scen, " R2 rx threshold"},  32'(rd_data[0]),     32'(m_rd[0]));
    chk({scen, " R3 tx threshold"},  32'(rd_data[1]),     32'(m_rd[1]));
    chk({scen, " R4 timeout flag"},  32'(rd_data[4]),     32'(m_rd[4]));
    chk({scen, " R5 bus error flag"}, 32'(rd_data[7]),    32'(m_rd[7]));
    chk({scen, " R8 empty bits"},    32'(rd_data[9:8]),   32'(m_rd[9:8]));
    chk({scen, " R9 rx count"},      32'(rd_data[23:16]), 32'(m_rd[23:16]));
    chk({scen, " R10 tx free"},      32'(rd_data[31:24]), 32'(m_rd[31:24]));
    chk({scen, " R11 reserved"},     rd_data & 32'h0000_FC6C, 32'h0);
  endtask

  task automatic cyc(input int rxl, input int txl, input int rxt, input int txt,
                     input bit en, input bit to, input bit be,
                     input bit we, input logic [31:0] wd, input bit re,
                     input string scen);
    int free;
    @(negedge clk);
    rx_level = CNT_W'(rxl); tx_level = CNT_W'(txl);
    rx_thresh = CNT_W'(rxt); tx_thresh = CNT_W'(txt);
    tx_enable = en; rx_timeout = to; bus_error = be;
    wr_en = we; wr_data = wd; rd_en = re;
    if (re) begin
      free = en ? (DEPTH - txl) : 0;
      m_rd = '0;
      m_rd[0] = (rxl >= rxt);
      m_rd[1] = (txl <= txt);
      m_rd[4] = m_to;
      m_rd[7] = m_be;
      m_rd[8] = (rxl == 0);
      m_rd[9] = (txl == 0);
      m_rd[23:16] = 8'(rxl);
      m_rd[31:24] = 8'(free);
    end
    m_to = to | (m_to & !(we & wd[4]));
    m_be = be | (m_be & !(we & wd[7]));
    @(posedge clk);
    #1;
    compare(scen);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset word", rd_data, 32'h0000_0300);
    @(negedge clk);
    rst = 0;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1 first read");
    // R2 R3 normal levels
    cyc(5, 3, 4, 4, 1, 0, 0, 0, 0, 1, "R2 above");
    cyc(3, 5, 4, 4, 1, 0, 0, 0, 0, 1, "R3 below");
    cyc(4, 4, 4, 4, 1, 0, 0, 0, 0, 1, "R2 equal");
    // R8 R9 R10 boundaries
    cyc(16, 16, 16, 0, 1, 0, 0, 0, 0, 1, "R10 full");
    cyc(0, 0, 1, 0, 1, 0, 0, 0, 0, 1, "R8 empty");
    cyc(7, 9, 2, 2, 0, 0, 0, 0, 0, 1, "R10 disabled");
    // R12 hold while inputs change
    cyc(11, 1, 3, 3, 1, 0, 0, 0, 0, 0, "R12 hold");
    cyc(2, 12, 9, 9, 1, 0, 0, 0, 0, 0, "R12 hold2");
    // R4 timeout sticky
    cyc(1, 1, 1, 1, 1, 1, 0, 0, 0, 0, "R4 pulse");
    cyc(1, 1, 1, 1, 1, 0, 0, 0, 0, 1, "R4 read set");
    cyc(1, 1, 1, 1, 1, 0, 0, 0, 0, 1, "R4 stays");
    cyc(1, 1, 1, 1, 1, 0, 0, 1, 32'hFFFF_FF6F, 1, "R7 other bits");
    cyc(1, 1, 1, 1, 1, 0, 0, 0, 0, 1, "R7 still set");
    cyc(1, 1, 1, 1, 1, 0, 0, 1, 32'h0000_0010, 1, "R4 clear same read");
    cyc(1, 1, 1, 1, 1, 0, 0, 0, 0, 1, "R4 cleared");
    // R5 bus error
    cyc(2, 2, 1, 1, 1, 0, 1, 0, 0, 0, "R5 pulse");
    cyc(2, 2, 1, 1, 1, 0, 0, 1, 32'h0000_0010, 1, "R7 wrong bit");
    cyc(2, 2, 1, 1, 1, 0, 0, 1, 32'h0000_0080, 1, "R5 clear");
    cyc(2, 2, 1, 1, 1, 0, 0, 0, 0, 1, "R5 cleared");
    // R6 collision
    cyc(3, 3, 1, 1, 1, 1, 1, 1, 32'h0000_0090, 0, "R6 collide");
    cyc(3, 3, 1, 1, 1, 0, 0, 0, 0, 1, "R6 survived");
    cyc(3, 3, 1, 1, 1, 0, 0, 1, 32'h0000_0090, 0, "R6 clear both");
    cyc(3, 3, 1, 1, 1, 0, 0, 0, 0, 1, "R6 gone");
    // sweep
    for (int i = 0; i <= DEPTH; i++)
      cyc(i, DEPTH - i, 8, 8, i[0], 0, 0, 0, 0, 1, "R9 sweep");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule